// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Divider

This block divides a stream of clock-enable pulses by a programmable integer ratio N. It sits in the feedback path of a frequency synthesizer and gives the phase comparator one pulse for every N input pulses. The divider works like a classic pulse-swallow chain. A prescaler counts modulo P or modulo P+1, a swallow counter decides how many prescaler periods use the larger modulus, and a main counter sets the length of the whole output cycle.

The requested ratio is split without help: the main count is N >> log2(P) and the swallow count is N mod P. The ratio is taken only at the end of an output cycle. A request that the chain cannot realise raises a flag and is not applied, and the divider goes on dividing by the last ratio it accepted. P is a power of two, 32 by default. The width of the main counter sets the largest ratio, so N can be set in steps of one.

Top module: `pswallow_div`

## Requirements
- R1: While rst_ni is low, pulse_o, illegal_o and mod_sel_o are 0. After release the divider runs at RESET_RATIO (default 1024), so the first pulse comes after exactly that many enabled cycles.
- R2: For an accepted ratio N, main count B = N >> log2(P) and swallow count A = N & (P-1). Every output cycle then lasts P·B + A = N enabled cycles.
- R3: Only cycles with en_i high advance the divider. Cycles with en_i low change nothing, so the period counted in enabled cycles does not depend on gaps in the enable stream.
- R4: In each output cycle, mod_sel_o (1 = prescaler divides by P+1) is high for exactly A·(P+1) enabled cycles, all of them before the P-modulus part.
- R5: pulse_o is high for one clock only. It is high in the cycle after the enabled cycle that completes the count.
- R6: ratio_i is sampled only in the enabled cycle that completes an output cycle. A change to ratio_i at any other time has no effect on the output cycle in progress.
- R7: A sampled ratio below P·(P-1) (992 for P = 32) is rejected. illegal_o rises together with that boundary's pulse, and the previously accepted ratio stays in force. P·(P-1) itself is accepted.
- R8: A sampled ratio whose swallow count exceeds its main count (for example 40: B = 1, A = 8) is rejected in the same way as R7.
- R9: illegal_o changes only at an output-cycle boundary. It returns to 0 at the first boundary that samples a legal ratio.
- R10: Ratios that differ by one give periods that differ by exactly one enabled cycle.
- R11: The largest ratio 2^(B_W+log2 P) - 1 (32767 by default) is supported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Input pulse (clock enable) to be divided |
| ratio_i | input | B_W+P_LOG2 | Requested division ratio N |
| pulse_o | output | 1 | One-clock pulse per N enabled cycles |
| mod_sel_o | output | 1 | Prescaler modulus select: 1 = P+1, 0 = P |
| illegal_o | output | 1 | Last sampled ratio was rejected |

## Verification
The assertions assume that RESET_RATIO is legal, so the active main count is never below the swallow count and never below P-1. Under that assumption the main counter cannot reach zero and pulses cannot come back to back. The stimulus changes ratio_i only away from clock edges. It keeps ratio_i steady across the boundary where the ratio is meant to be sampled, so that the boundary at which a value takes effect is known exactly. The enable stream is either always high or a fixed two-of-three gap pattern. Both patterns give enough enabled cycles for every count to finish well inside the run.

// File: rtl/pswallow_pkg.sv
`timescale 1ns/1ps
package pswallow_pkg;
  localparam int unsigned DEF_P_LOG2      = 5;
  localparam int unsigned DEF_B_W         = 10;
  localparam int unsigned DEF_RESET_RATIO = 1024;

  // smallest ratio reachable without gaps: P*(P-1)
  function automatic int unsigned min_ratio(input int unsigned p_log2);
    return (32'd1 << p_log2) * ((32'd1 << p_log2) - 32'd1);
  endfunction
endpackage

// File: rtl/pswallow_split.sv
`timescale 1ns/1ps
module pswallow_split
  import pswallow_pkg::*;
#(
  parameter int unsigned P_LOG2 = DEF_P_LOG2,
  parameter int unsigned B_W    = DEF_B_W,
  localparam int unsigned N_W   = B_W + P_LOG2
) (
  input  logic [N_W-1:0]    ratio_i,
  output logic [B_W-1:0]    main_o,
  output logic [P_LOG2-1:0] swal_o,
  output logic              legal_o
);
  localparam logic [N_W-1:0] MIN_N = N_W'(min_ratio(P_LOG2));

  logic below_min;
  logic swal_over;

  always_comb begin
    main_o    = ratio_i[N_W-1:P_LOG2];
    swal_o    = ratio_i[P_LOG2-1:0];
    below_min = ratio_i < MIN_N;
    swal_over = 32'(swal_o) > 32'(main_o);
    legal_o   = !below_min && !swal_over;
  end
endmodule

// File: rtl/pswallow_presc.sv
`timescale 1ns/1ps
module pswallow_presc #(
  parameter int unsigned P_LOG2 = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic mod_hi_i,
  output logic wrap_o
);
  localparam int unsigned P  = 1 << P_LOG2;
  localparam int unsigned CW = P_LOG2 + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_val;

  always_comb begin
    last_val = mod_hi_i ? CW'(P) : CW'(P - 1);
    wrap_o   = en_i && (cnt_q == last_val);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (en_i)  cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
  end

  // modulus drops only when the count has just wrapped to zero
  assert_presc_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_q) < (mod_hi_i ? P + 1 : P));
endmodule

// File: rtl/pswallow_ctrs.sv
`timescale 1ns/1ps
module pswallow_ctrs #(
  parameter int unsigned P_LOG2   = 5,
  parameter int unsigned B_W      = 10,
  parameter int unsigned RST_MAIN = 32,
  parameter int unsigned RST_SWAL = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              load_i,
  input  logic [B_W-1:0]    main_ld_i,
  input  logic [P_LOG2-1:0] swal_ld_i,
  output logic              swal_act_o,
  output logic              last_o
);
  logic [B_W-1:0]    main_q;
  logic [P_LOG2-1:0] swal_q;

  always_comb begin
    swal_act_o = swal_q != '0;
    last_o     = main_q == B_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      main_q <= B_W'(RST_MAIN);
      swal_q <= P_LOG2'(RST_SWAL);
    end else if (load_i) begin
      main_q <= main_ld_i;
      swal_q <= swal_ld_i;
    end else if (step_i) begin
      main_q <= main_q - 1'b1;
      if (swal_act_o) swal_q <= swal_q - 1'b1;
    end
  end

  assert_swal_le_main_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(swal_q) <= 32'(main_q));
  assert_main_nonzero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    main_q != '0);
endmodule

// File: rtl/pswallow_div.sv
`timescale 1ns/1ps
module pswallow_div
  import pswallow_pkg::*;
#(
  parameter int unsigned P_LOG2      = DEF_P_LOG2,
  parameter int unsigned B_W         = DEF_B_W,
  parameter int unsigned RESET_RATIO = DEF_RESET_RATIO,
  localparam int unsigned N_W        = B_W + P_LOG2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic [N_W-1:0] ratio_i,
  output logic           pulse_o,
  output logic           mod_sel_o,
  output logic           illegal_o
);
  localparam int unsigned     P        = 1 << P_LOG2;
  localparam int unsigned     RST_MAIN = RESET_RATIO >> P_LOG2;
  localparam int unsigned     RST_SWAL = RESET_RATIO % P;
  localparam logic [N_W-1:0]  MIN_N    = N_W'(min_ratio(P_LOG2));

  logic [B_W-1:0]    req_main, act_main_q, ld_main;
  logic [P_LOG2-1:0] req_swal, act_swal_q, ld_swal;
  logic              req_legal;
  logic              wrap, last, swal_act, boundary;
  logic              pulse_q, illegal_q;

  pswallow_split #(.P_LOG2(P_LOG2), .B_W(B_W)) u_split (
    .ratio_i (ratio_i),
    .main_o  (req_main),
    .swal_o  (req_swal),
    .legal_o (req_legal)
  );

  pswallow_presc #(.P_LOG2(P_LOG2)) u_presc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .mod_hi_i (swal_act),
    .wrap_o   (wrap)
  );

  always_comb begin
    boundary = wrap && last;
    ld_main  = req_legal ? req_main : act_main_q;
    ld_swal  = req_legal ? req_swal : act_swal_q;
  end

  pswallow_ctrs #(
    .P_LOG2   (P_LOG2),
    .B_W      (B_W),
    .RST_MAIN (RST_MAIN),
    .RST_SWAL (RST_SWAL)
  ) u_ctrs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (wrap),
    .load_i     (boundary),
    .main_ld_i  (ld_main),
    .swal_ld_i  (ld_swal),
    .swal_act_o (swal_act),
    .last_o     (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_main_q <= B_W'(RST_MAIN);
      act_swal_q <= P_LOG2'(RST_SWAL);
      pulse_q    <= 1'b0;
      illegal_q  <= 1'b0;
    end else begin
      pulse_q <= boundary;
      if (boundary) begin
        illegal_q <= !req_legal;
        if (req_legal) begin
          act_main_q <= req_main;
          act_swal_q <= req_swal;
        end
      end
    end
  end

  assign pulse_o   = pulse_q;
  assign illegal_o = illegal_q;
  assign mod_sel_o = swal_act;

  assert_pulse_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
  assert_pulse_after_en_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> $past(en_i));
  assert_flag_at_boundary_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(illegal_o) |-> pulse_o);
  assert_modsel_on_en_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mod_sel_o) |-> $past(en_i));
  assert_active_legal_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({act_main_q, act_swal_q} >= MIN_N) && (32'(act_swal_q) <= 32'(act_main_q)));
endmodule

// File: tb/pswallow_div_test.sv
`timescale 1ns/1ps
module pswallow_div_test;
  localparam int unsigned N_W = 15;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           en = 1'b0;
  logic [N_W-1:0] ratio = N_W'(1024);
  logic           pulse, mod_sel, illegal;

  int n_cmp = 0, n_err = 0;
  int en_cnt = 0, mod_cnt = 0, last_per = 0, last_mod = 0, n_per = 0, dbl = 0;
  int cyc = 0;
  bit prev_pulse = 0, gap = 0;

  always #2 clk = ~clk;

  pswallow_div uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .en_i      (en),
    .ratio_i   (ratio),
    .pulse_o   (pulse),
    .mod_sel_o (mod_sel),
    .illegal_o (illegal)
  );

  initial forever begin
    @(posedge clk); #1;
    cyc++;
    en = rst_n && (!gap || (cyc % 3 != 0));
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      en_cnt = 0; mod_cnt = 0; prev_pulse = 0;
    end else begin
      if (pulse) begin
        last_per = en_cnt; last_mod = mod_cnt; n_per++;
        en_cnt = 0; mod_cnt = 0;
        if (prev_pulse) dbl++;
      end
      prev_pulse = pulse;
      if (en) begin
        en_cnt++;
        if (mod_sel) mod_cnt++;
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", n_per, -1);
    summary();
    $finish;
  end

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic next_period();
    int start = n_per;
    do begin @(negedge clk); #1; end while (n_per == start);
  endtask

  // apply after a boundary; the period in flight keeps the old ratio
  task automatic apply_ratio(input int r);
    ratio = N_W'(r);
    next_period();
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    check("R1 pulse in reset", int'(pulse), 0);
    check("R1 illegal in reset", int'(illegal), 0);
    check("R1 mod_sel in reset", int'(mod_sel), 0);
    rst_n = 1'b1;
    next_period();
    check("R1 first period", last_per, 1024);
    check("R1 illegal after boot", int'(illegal), 0);
  endtask

  task automatic t_split();
    ratio = N_W'(1000);
    next_period();
    check("R6 in-flight period keeps old ratio", last_per, 1024);
    next_period();
    check("R2 period 1000", last_per, 1000);
    check("R4 wide-modulus cycles 1000", last_mod, 8 * 33);
    apply_ratio(1001);
    next_period();
    check("R10 period 1001", last_per, 1001);
    check("R4 wide-modulus cycles 1001", last_mod, 9 * 33);
    check("R5 no back-to-back pulse", dbl, 0);
  endtask

  task automatic t_gapped();
    gap = 1;
    apply_ratio(1055);
    next_period();
    check("R3 gapped period 1055", last_per, 1055);
    check("R4 gapped wide cycles", last_mod, 31 * 33);
    gap = 0;
  endtask

  task automatic t_midchange();
    apply_ratio(1000);
    repeat (200) @(negedge clk);
    #1 ratio = N_W'(1500);
    repeat (50) @(negedge clk);
    #1 ratio = N_W'(1000);
    next_period();
    check("R6 mid-cycle change ignored", last_per, 1000);
    next_period();
    check("R6 next period unaffected", last_per, 1000);
  endtask

  task automatic t_minimum();
    apply_ratio(992);
    next_period();
    check("R7 minimum ratio accepted", last_per, 992);
    check("R7 minimum not flagged", int'(illegal), 0);
    check("R4 zero swallow", last_mod, 0);
  endtask

  task automatic t_below();
    ratio = N_W'(991);
    next_period();
    check("R7 flag raised at boundary", int'(illegal), 1);
    next_period();
    check("R7 previous ratio kept", last_per, 992);
    check("R9 flag held", int'(illegal), 1);
  endtask

  task automatic t_swal_over();
    ratio = N_W'(40);
    next_period();
    check("R8 flag for swallow above main", int'(illegal), 1);
    next_period();
    check("R8 previous ratio kept", last_per, 992);
  endtask

  task automatic t_recover();
    ratio = N_W'(1023);
    next_period();
    check("R9 flag cleared on legal ratio", int'(illegal), 0);
    next_period();
    check("R9 new ratio active", last_per, 1023);
    check("R4 all periods wide", last_mod, 1023);
  endtask

  task automatic t_max();
    apply_ratio(32767);
    next_period();
    check("R11 largest ratio", last_per, 32767);
    check("R11 largest ratio wide cycles", last_mod, 31 * 33);
    check("R5 single-cycle pulses", dbl, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_split();
    t_gapped();
    t_midchange();
    t_minimum();
    t_below();
    t_swal_over();
    t_recover();
    t_max();
    summary();
    $finish;
  end
endmodule